// File: doc/BRIEF.md
# Prefetch Read Data Flush Controller

This block sits beside the inbound read prefetch buffer of a bus bridge. It decides when the prefetched data has gone stale and must be thrown away. It tracks the prefetched window as a base dword address and a length in dwords. It watches strobes for inbound read accept, inbound read completion, inbound writes, and the start of outbound writes and reads. When one of these calls for a discard, it raises a one-cycle flush pulse and drops its valid flag.

A programmable timeout starts when an inbound read completes. It counts down one step per clock. It stops when the next inbound read is accepted, and it keeps counting through inbound writes and all outbound traffic. A two-bit policy selects which events cause a discard. Some discards apply under every policy: a read that does not continue the current window, and a write that touches the window.

Top module: `prefetch_flush_ctrl`

## Requirements
- R1: After reset, `pf_valid_o` and `flush_o` are both 0.
- R2: When `rd_done_i` is seen with timeout select s (0..6) and policy not 00, `flush_o` goes high exactly 4<<s clock edges after the edge that captured `rd_done_i`, provided no other event intervenes. The counts are 4, 8, 16, 32, 64, 128 and 256.
- R3: Timeout select 7 disables the timeout, so the window stays valid with no flush.
- R4: An accepted inbound read stops a running timeout, and no timeout flush follows it.
- R5: Inbound writes outside the window and outbound starts that the policy does not name leave the countdown running, with no change to its length.
- R6: Policy 00 flushes on the edge that captures `rd_done_i`.
- R7: Policy 10 flushes on an outbound write start, but not on an outbound read start.
- R8: Policy 11 flushes on either an outbound write start or an outbound read start.
- R9: Under any policy, an accepted read whose address is not base+length flushes the old window and opens a new one at the read's address. In that cycle `flush_o` is 1 and `pf_valid_o` stays 1.
- R10: A read whose address equals base+length extends the window by its length and does not flush.
- R11: Under any policy, an inbound write whose range [addr, addr+len) overlaps the window flushes it. A write outside the window does not flush.
- R12: The timeout select is captured at load, so changing it during a countdown does not change that countdown.
- R13: A flush pulse is only produced while the window is valid. Events seen with no valid window produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmo_sel_i | input | 3 | Timeout select, 4<<s clocks; 7 = off |
| policy_i | input | 2 | Discard policy: 00 end of read, 01 timeout only, 10 +outbound write, 11 +outbound write/read |
| rd_accept_i | input | 1 | Inbound read accepted strobe |
| rd_addr_i | input | ADDR_W | Dword start address of accepted read |
| rd_len_i | input | LEN_W | Dwords prefetched by accepted read |
| rd_done_i | input | 1 | Inbound read transaction completed |
| wr_i | input | 1 | Inbound write strobe |
| wr_addr_i | input | ADDR_W | Dword start address of inbound write |
| wr_len_i | input | LEN_W | Dword length of inbound write (at least 1) |
| ob_wr_start_i | input | 1 | Outbound write start strobe |
| ob_rd_start_i | input | 1 | Outbound read start strobe |
| flush_o | output | 1 | One-cycle discard pulse |
| pf_valid_o | output | 1 | Prefetched window holds data |

## Verification
The assertions assume that `rd_accept_i` and `rd_done_i` never assert in the same cycle. They also assume that write lengths are non-zero and that the window's total length never overflows LEN_W bits. The random stimulus keeps to these limits: it masks the accept strobe whenever it would collide with a completion, draws write and read lengths from 1 to 8, and suppresses accepts once the tracked window grows past 900 dwords. Addresses come from a narrow range, and half of the accepts are steered to base+length, so contiguous reads, non-contiguous reads and overlapping writes all occur often.

// File: rtl/pf_flush_pkg.sv
package pf_flush_pkg;
  typedef enum logic [1:0] {
    POL_END  = 2'b00,
    POL_TMO  = 2'b01,
    POL_OBW  = 2'b10,
    POL_OBRW = 2'b11
  } pol_e;

  localparam int unsigned TMO_W   = 9;
  localparam logic [2:0]  TMO_OFF = 3'd7;

  function automatic logic [TMO_W-1:0] tmo_count(input logic [2:0] sel);
    return TMO_W'(4) << sel;
  endfunction
endpackage

// File: rtl/pf_window.sv
module pf_window #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [LEN_W-1:0]  acc_len_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  output logic              valid_o,
  output logic              contig_o,
  output logic              overlap_o
);
  localparam int unsigned EW = ADDR_W + 1;

  logic              valid_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [EW-1:0]     win_end, wr_end;

  assign win_end   = EW'(base_q) + EW'(len_q);
  assign wr_end    = EW'(wr_addr_i) + EW'(wr_len_i);
  assign contig_o  = (acc_addr_i == win_end[ADDR_W-1:0]);
  assign overlap_o = (EW'(wr_addr_i) < win_end) && (EW'(base_q) < wr_end);
  assign valid_o   = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
    end else if (acc_i) begin
      valid_q <= 1'b1;
      if (flush_i || !valid_q) begin
        base_q <= acc_addr_i;
        len_q  <= acc_len_i;
      end else begin
        len_q  <= len_q + acc_len_i;
      end
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end
  end

  // R9
  acc_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> valid_q);
endmodule

// File: rtl/pf_timer.sv
module pf_timer
  import pf_flush_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] sel_i,
  input  logic       stop_i,
  output logic       run_o,
  output logic       hit_o
);
  logic             run_q;
  logic [TMO_W-1:0] cnt_q;

  assign run_o = run_q;
  assign hit_o = run_q && (cnt_q == TMO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= tmo_count(sel_i);
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2: reaching zero must always coincide with a stop from the flush logic
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q != '0);
endmodule

// File: rtl/prefetch_flush_ctrl.sv
module prefetch_flush_ctrl
  import pf_flush_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        tmo_sel_i,
  input  logic [1:0]        policy_i,
  input  logic              rd_accept_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  input  logic              rd_done_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic              ob_wr_start_i,
  input  logic              ob_rd_start_i,
  output logic              flush_o,
  output logic              pf_valid_o
);
  pol_e pol;
  logic win_valid, contig, overlap;
  logic tmr_run, tmr_hit, tmr_load;
  logic pol_hit, flush_req, valid_next, flush_q;

  assign pol = pol_e'(policy_i);

  always_comb begin
    unique case (pol)
      POL_END:  pol_hit = rd_done_i;
      POL_TMO:  pol_hit = 1'b0;
      POL_OBW:  pol_hit = ob_wr_start_i;
      POL_OBRW: pol_hit = ob_wr_start_i || ob_rd_start_i;
      default:  pol_hit = 1'b0;
    endcase
  end

  assign flush_req = win_valid && (pol_hit || tmr_hit ||
                                   (rd_accept_i && !contig) ||
                                   (wr_i && overlap));
  assign valid_next = rd_accept_i || (win_valid && !flush_req);
  assign tmr_load   = rd_done_i && (pol != POL_END) &&
                      (tmo_sel_i != TMO_OFF) && valid_next;

  pf_window #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (rd_accept_i),
    .acc_addr_i(rd_addr_i),
    .acc_len_i (rd_len_i),
    .flush_i   (flush_req),
    .wr_addr_i (wr_addr_i),
    .wr_len_i  (wr_len_i),
    .valid_o   (win_valid),
    .contig_o  (contig),
    .overlap_o (overlap)
  );

  pf_timer u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .sel_i (tmo_sel_i),
    .stop_i(flush_req || rd_accept_i),
    .run_o (tmr_run),
    .hit_o (tmr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= flush_req;
  end

  assign flush_o    = flush_q;
  assign pf_valid_o = win_valid;

  // R2
  tmo_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_hit |=> flush_o);
  // R4
  acc_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_accept_i && !rd_done_i) |=> !tmr_run);
  // R13
  no_idle_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pf_valid_o && !rd_accept_i) |=> !flush_o);
  // R9
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !$past(rd_accept_i)) |-> !pf_valid_o);
endmodule

// File: tb/sim_prefetch_flush_ctrl.sv
module sim_prefetch_flush_ctrl;
  localparam int AW = 16;
  localparam int LW = 10;
  localparam int CLK_NS = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] tmo_sel = '0;
  logic [1:0] policy = '0;
  logic rd_accept = 0, rd_done = 0, wr = 0, ob_wr = 0, ob_rd = 0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [LW-1:0] rd_len = '0, wr_len = '0;
  logic flush_o, pf_valid_o;

  int total = 0, bad = 0;
  string tag = "RND";

  // reference state
  bit m_valid, m_run, m_flush;
  int m_base, m_len, m_cnt;

  always #(CLK_NS/2) clk = ~clk;

  prefetch_flush_ctrl #(.ADDR_W(AW), .LEN_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tmo_sel_i(tmo_sel), .policy_i(policy),
    .rd_accept_i(rd_accept), .rd_addr_i(rd_addr), .rd_len_i(rd_len),
    .rd_done_i(rd_done), .wr_i(wr), .wr_addr_i(wr_addr), .wr_len_i(wr_len),
    .ob_wr_start_i(ob_wr), .ob_rd_start_i(ob_rd),
    .flush_o(flush_o), .pf_valid_o(pf_valid_o));

  function automatic bit pol_event(int p, bit d, bit ow, bit orr);
    case (p)
      0: return d;
      2: return ow;
      3: return ow | orr;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string t, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", t, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int wend = m_base + m_len;
    bit contig = (int'(rd_addr) == (wend % (1 << AW)));
    bit ovl = (int'(wr_addr) < wend) && (m_base < int'(wr_addr) + int'(wr_len));
    bit hit = m_run && (m_cnt == 1);
    bit freq = m_valid && (pol_event(policy, rd_done, ob_wr, ob_rd) || hit ||
                           (rd_accept && !contig) || (wr && ovl));
    bit nvalid = rd_accept || (m_valid && !freq);
    if (rd_accept) begin
      if (freq || !m_valid) begin m_base = rd_addr; m_len = rd_len; end
      else m_len = m_len + rd_len;
    end
    if (rd_done && policy != 0 && tmo_sel != 7 && nvalid) begin
      m_run = 1; m_cnt = 4 << tmo_sel;
    end else if (freq || rd_accept) m_run = 0;
    else if (m_run) m_cnt--;
    m_valid = nvalid;
    m_flush = freq;
  endtask

  task automatic step();
    model_update();
    @(posedge clk); #1;
    chk(flush_o == m_flush, {tag, " flush"}, flush_o, m_flush);
    chk(pf_valid_o == m_valid, {tag, " valid"}, pf_valid_o, m_valid);
    rd_accept = 0; rd_done = 0; wr = 0; ob_wr = 0; ob_rd = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    m_valid = 0; m_run = 0; m_flush = 0; m_base = 0; m_len = 0; m_cnt = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  task automatic accept(int a, int l);
    rd_accept = 1; rd_addr = AW'(a); rd_len = LW'(l); step();
  endtask

  task automatic done(int s);
    rd_done = 1; tmo_sel = 3'(s); step();
  endtask

  // counts edges after the done edge until flush, up to lim
  task automatic wait_flush(int lim, output int n);
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      step();
      if (flush_o) begin n = k; break; end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    tag = "R1";
    chk(pf_valid_o == 0, "R1 valid", pf_valid_o, 0);
    chk(flush_o == 0, "R1 flush", flush_o, 0);

    // R2 every timeout length
    tag = "R2"; policy = 2'b01;
    for (int s = 0; s < 7; s++) begin
      accept(100, 4); done(s); wait_flush(300, n);
      chk(n == (4 << s), "R2 timeout", n, 4 << s);
    end

    // R3 disabled
    tag = "R3";
    accept(100, 4); done(7); wait_flush(300, n);
    chk(n == 0 && pf_valid_o, "R3 no timeout", n, 0);

    // R4 accept stops counter
    do_reset(); tag = "R4"; policy = 2'b01;
    accept(100, 4); done(0); step();
    accept(104, 2); wait_flush(300, n);
    chk(n == 0 && pf_valid_o, "R4 stopped", n, 0);

    // R5 non-overlapping write and outbound traffic keep counting
    do_reset(); tag = "R5"; policy = 2'b01;
    accept(100, 4); done(1);
    wr = 1; wr_addr = 16'd300; wr_len = 10'd2; step();
    ob_wr = 1; step();
    ob_rd = 1; step();
    wait_flush(20, n);
    chk(n + 3 == 8, "R5 count through", n + 3, 8);

    // R6 policy end-of-read
    do_reset(); tag = "R6"; policy = 2'b00;
    accept(100, 4); done(3);
    chk(flush_o == 1 && pf_valid_o == 0, "R6 flush at done", flush_o, 1);

    // R7 policy outbound write only
    do_reset(); tag = "R7"; policy = 2'b10;
    accept(100, 4); ob_rd = 1; step();
    chk(flush_o == 0, "R7 obrd ignored", flush_o, 0);
    ob_wr = 1; step();
    chk(flush_o == 1, "R7 obwr flush", flush_o, 1);

    // R13 nothing to flush
    tag = "R13"; policy = 2'b11; ob_wr = 1; step();
    chk(flush_o == 0, "R13 idle", flush_o, 0);

    // R8 policy outbound read too
    tag = "R8"; accept(100, 4); ob_rd = 1; step();
    chk(flush_o == 1, "R8 obrd flush", flush_o, 1);

    // R9 non-contiguous read
    do_reset(); tag = "R9"; policy = 2'b01;
    accept(500, 4); accept(600, 2);
    chk(flush_o == 1 && pf_valid_o == 1, "R9 reopen", flush_o, 1);
    accept(602, 1);
    chk(flush_o == 0, "R9 new base", flush_o, 0);

    // R10 contiguous extension
    do_reset(); tag = "R10"; policy = 2'b01;
    accept(200, 4); accept(204, 4);
    chk(flush_o == 0 && pf_valid_o, "R10 extend", flush_o, 0);
    wr = 1; wr_addr = 16'd207; wr_len = 10'd1; step();
    chk(flush_o == 1, "R10 extended end", flush_o, 1);

    // R11 overlap write
    tag = "R11"; accept(300, 4);
    wr = 1; wr_addr = 16'd304; wr_len = 10'd2; step();
    chk(flush_o == 0, "R11 adjacent", flush_o, 0);
    wr = 1; wr_addr = 16'd299; wr_len = 10'd2; step();
    chk(flush_o == 1, "R11 overlap", flush_o, 1);

    // R12 select sampled at load
    do_reset(); tag = "R12"; policy = 2'b01;
    accept(100, 4); done(2); tmo_sel = 3'd6; wait_flush(300, n);
    chk(n == 16, "R12 sampled", n, 16);

    // random mix
    do_reset(); tag = "RND";
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) policy = 2'($urandom_range(3));
      tmo_sel = 3'($urandom_range(7));
      rd_done = ($urandom_range(9) == 0);
      rd_accept = !rd_done && ($urandom_range(7) == 0) && (m_len < 900);
      rd_len = LW'($urandom_range(8, 1));
      rd_addr = $urandom_range(1) ? AW'(m_base + m_len) : AW'($urandom_range(63));
      wr = ($urandom_range(15) == 0);
      wr_addr = AW'($urandom_range(80));
      wr_len = LW'($urandom_range(8, 1));
      ob_wr = ($urandom_range(15) == 0);
      ob_rd = ($urandom_range(15) == 0);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule